// File: doc/BRIEF.md
# Processor Reset Type Controller

This block sits next to a processor core and turns three raw, active-high reset inputs (core, chip, system) into a clean core-reset sequence. An input counts only after it has been sampled high on a run of consecutive clock edges. The block then holds the core in reset while the core input stays asserted, and for a fixed tail after the input is released. It also records the kind of the most recent qualified reset in a two-bit field that software can read and clear.

The system input does not reset the core. It drives a separate debug-unit reset that follows the input one cycle later. The block also gathers reset requests from two sources: a write to a debug-control reset field, and a watchdog whose reset-control field selects a system reset. It raises a sticky system-reset request towards the board. That request resets nothing inside the block. External logic answers it by driving the system reset input. A qualified system input then withdraws the request.

A small register port reaches three fields: address 0 is the debug-control reset field, address 1 is the watchdog reset-control field, and address 2 clears bits of the recorded type (write-one-to-clear). Address 3 has no effect.

Top module: `rst_type_ctrl`

## Requirements
- R1: While rst_ni is low, core_rst_o=1, dbg_rst_o=1, rst_type_o=00 and sys_rst_req_o=0. After rst_ni rises, core_rst_o stays 1 for 16 rising clock edges and reads 0 after the 16th.
- R2: When core_rst_i is sampled high on 8 consecutive rising edges, core_rst_o is 1 after the 8th edge and rst_type_o is 01 (core), unless chip or system also qualify (see R5, R6).
- R3: A core_rst_i pulse shorter than 8 sampled edges, including a broken run of pulses, leaves core_rst_o at 0 and rst_type_o unchanged.
- R4: core_rst_o stays 1 while the qualified core_rst_i remains high. After the first edge that samples core_rst_i low, it stays 1 for 16 more edges and reads 0 after the 17th edge.
- R5: chip_rst_i held together with core_rst_i for 8 edges records type 10 (chip). chip_rst_i alone, for any length, neither changes rst_type_o nor asserts core_rst_o.
- R6: When several inputs are qualified and core_rst_i is qualified, the recorded type follows the priority system (11) over chip (10) over core (01). If chip or system qualifies later while core is still held, the type is upgraded at that qualification.
- R7: dbg_rst_o equals sys_rst_i delayed by one edge, with no qualification. sys_rst_i alone neither asserts core_rst_o nor changes rst_type_o.
- R8: A register write to address 0 with data 11 sets sys_rst_req_o after that edge. Other data values have no effect, and so does any such write while dbg_rst_o is 1.
- R9: With the watchdog field (address 1) at 11, a wdog_timeout_i pulse moves the watchdog to its fired state and sets sys_rst_req_o. Other field values give no request. A timeout in the fired state gives no new request. A core qualification returns the watchdog to idle and clears the field to 00.
- R10: sys_rst_req_o is sticky and does not touch core_rst_o or rst_type_o. It clears on the edge at which sys_rst_i completes 8 consecutive high samples, and that clear wins over a set in the same cycle.
- R11: A write to address 2 clears each rst_type_o bit whose data bit is 1. A reset qualification in the same cycle wins over the clear.
- R12: rst_type_o holds until the next qualified reset. A core qualification during the 16-cycle release tail re-enters the hold without core_rst_o ever dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| core_rst_i | input | 1 | Core reset input, active high |
| chip_rst_i | input | 1 | Chip reset type select, active high |
| sys_rst_i | input | 1 | System reset input, resets the debug unit and selects the system type |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | 0 debug reset field, 1 watchdog reset field, 2 type clear |
| reg_wdata_i | input | 2 | Write data |
| wdog_timeout_i | input | 1 | Watchdog time-out pulse |
| core_rst_o | output | 1 | Internal core reset |
| dbg_rst_o | output | 1 | Debug-unit reset |
| rst_type_o | output | 2 | Most recent reset type: 00 none, 01 core, 10 chip, 11 system |
| sys_rst_req_o | output | 1 | Sticky system-reset request towards external logic |

## Verification
A qualification counter that miscounts shows up as core_rst_o rising one edge early or late relative to the 8th sample, or, if it fails to clear, as a broken pulse train qualifying. Both are visible on the edge itself. A wrong release-tail count moves the fall of core_rst_o away from edge 17, and a wrong priority shows as the wrong code on rst_type_o on the cycle of qualification. A watchdog stuck in the wrong state appears only on a later time-out, as a request that should or should not appear one edge after the pulse. The bench therefore drives time-outs in every state it can reach.

// File: rtl/rst_type_pkg.sv
package rst_type_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_CORE = 0;
  localparam int SRC_CHIP = 1;
  localparam int SRC_SYS  = 2;

  localparam logic [1:0] TYPE_NONE = 2'b00;
  localparam logic [1:0] TYPE_CORE = 2'b01;
  localparam logic [1:0] TYPE_CHIP = 2'b10;
  localparam logic [1:0] TYPE_SYS  = 2'b11;

  localparam logic [1:0] ADDR_DBG = 2'd0;
  localparam logic [1:0] ADDR_WDG = 2'd1;
  localparam logic [1:0] ADDR_CLR = 2'd2;

  localparam logic [1:0] FLD_SYS_REQ = 2'b11;

  typedef enum logic [1:0] {SEQ_RUN, SEQ_HOLD, SEQ_DRAIN} seq_state_e;
  typedef enum logic {WD_IDLE, WD_FIRED} wd_state_e;
endpackage

// File: rtl/rst_qual_cnt.sv
module rst_qual_cnt #(
  parameter int QUAL_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_in_i,
  output logic hit_o,
  output logic qual_next_o
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(QUAL_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!rst_in_i)    cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // hit: this edge completes the run; qual_next: input qualified after this edge
  assign hit_o       = rst_in_i && (cnt_q == CNT_LAST);
  assign qual_next_o = rst_in_i && (cnt_q >= CNT_LAST);
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_type_pkg::*;
#(
  parameter int DRAIN_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic core_in_i,
  input  logic core_hit_i,
  output logic core_rst_o
);
  localparam int DW = (DRAIN_CYC > 1) ? $clog2(DRAIN_CYC) : 1;
  localparam logic [DW-1:0] DCNT_LAST = DW'(DRAIN_CYC - 1);

  seq_state_e    state_q, state_d;
  logic [DW-1:0] dcnt_q, dcnt_d;

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    unique case (state_q)
      SEQ_RUN:  if (core_hit_i) state_d = SEQ_HOLD;
      SEQ_HOLD: if (!core_in_i) begin
        state_d = SEQ_DRAIN;
        dcnt_d  = '0;
      end
      SEQ_DRAIN: begin
        if (core_hit_i)                 state_d = SEQ_HOLD;
        else if (dcnt_q == DCNT_LAST)   state_d = SEQ_RUN;
        else                            dcnt_d  = dcnt_q + 1'b1;
      end
      default: state_d = SEQ_DRAIN;
    endcase
  end

  // power-on enters the release tail directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_DRAIN;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
    end
  end

  assign core_rst_o = (state_q != SEQ_RUN);
endmodule

// File: rtl/rst_req_ctl.sv
module rst_req_ctl
  import rst_type_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [1:0] reg_wdata_i,
  input  logic       wdog_timeout_i,
  input  logic       dbg_rst_i,
  input  logic       core_hit_i,
  input  logic       sys_hit_i,
  output logic       req_o
);
  logic [1:0] wrc_q;
  wd_state_e  wd_q, wd_d;
  logic       dbg_set, wd_set, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   wrc_q <= 2'b00;
    else if (core_hit_i)                           wrc_q <= 2'b00;
    else if (reg_we_i && reg_addr_i == ADDR_WDG)   wrc_q <= reg_wdata_i;
  end

  assign wd_set = (wd_q == WD_IDLE) && wdog_timeout_i && (wrc_q == FLD_SYS_REQ);

  always_comb begin
    wd_d = wd_q;
    unique case (wd_q)
      WD_IDLE:  if (wd_set)     wd_d = WD_FIRED;
      WD_FIRED: if (core_hit_i) wd_d = WD_IDLE;
      default:  wd_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wd_q <= WD_IDLE;
    else         wd_q <= wd_d;
  end

  // debug field writes are dropped while the debug unit is in reset
  assign dbg_set = reg_we_i && (reg_addr_i == ADDR_DBG) &&
                   (reg_wdata_i == FLD_SYS_REQ) && !dbg_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 req_q <= 1'b0;
    else if (sys_hit_i)          req_q <= 1'b0;
    else if (dbg_set || wd_set)  req_q <= 1'b1;
  end

  assign req_o = req_q;
endmodule

// File: rtl/rst_type_ctrl.sv
module rst_type_ctrl
  import rst_type_pkg::*;
#(
  parameter int QUAL_CYC  = 8,
  parameter int DRAIN_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       core_rst_i,
  input  logic       chip_rst_i,
  input  logic       sys_rst_i,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [1:0] reg_wdata_i,
  input  logic       wdog_timeout_i,
  output logic       core_rst_o,
  output logic       dbg_rst_o,
  output logic [1:0] rst_type_o,
  output logic       sys_rst_req_o
);
  logic [NUM_SRC-1:0] src_in, src_hit, src_qn;
  logic               type_evt;
  logic [1:0]         new_type, type_q;
  logic               dbg_rst_q;

  assign src_in = {sys_rst_i, chip_rst_i, core_rst_i};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
    rst_qual_cnt #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rst_in_i    (src_in[i]),
      .hit_o       (src_hit[i]),
      .qual_next_o (src_qn[i])
    );
  end

  // record only while core is qualified; any fresh qualification re-evaluates
  assign type_evt = src_qn[SRC_CORE] && (|src_hit);

  always_comb begin
    if (src_qn[SRC_SYS])       new_type = TYPE_SYS;
    else if (src_qn[SRC_CHIP]) new_type = TYPE_CHIP;
    else                       new_type = TYPE_CORE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  type_q <= TYPE_NONE;
    else if (type_evt)                            type_q <= new_type;
    else if (reg_we_i && reg_addr_i == ADDR_CLR)  type_q <= type_q & ~reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dbg_rst_q <= 1'b1;
    else         dbg_rst_q <= sys_rst_i;
  end

  rst_seq #(.DRAIN_CYC(DRAIN_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_in_i  (core_rst_i),
    .core_hit_i (src_hit[SRC_CORE]),
    .core_rst_o (core_rst_o)
  );

  rst_req_ctl u_req (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .reg_we_i       (reg_we_i),
    .reg_addr_i     (reg_addr_i),
    .reg_wdata_i    (reg_wdata_i),
    .wdog_timeout_i (wdog_timeout_i),
    .dbg_rst_i      (dbg_rst_q),
    .core_hit_i     (src_hit[SRC_CORE]),
    .sys_hit_i      (src_hit[SRC_SYS]),
    .req_o          (sys_rst_req_o)
  );

  assign dbg_rst_o  = dbg_rst_q;
  assign rst_type_o = type_q;
endmodule

// File: rtl/rst_type_ctrl_chk.sv
module rst_type_ctrl_chk #(
  parameter int QUAL_CYC = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_rst_i,
  input logic       chip_rst_i,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i,
  input logic [1:0] reg_wdata_i,
  input logic       wdog_timeout_i,
  input logic       core_rst_o,
  input logic       dbg_rst_o,
  input logic [1:0] rst_type_o,
  input logic       sys_rst_req_o
);
  int unsigned core_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             core_hi_cnt <= 0;
    else if (!core_rst_i)                    core_hi_cnt <= 0;
    else if (core_hi_cnt < QUAL_CYC)         core_hi_cnt <= core_hi_cnt + 1;
  end

  // R2
  core_qual_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> (core_hi_cnt >= QUAL_CYC));

  // R4
  core_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> !$past(core_rst_i));

  // R5
  chip_type_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_type_o == 2'b10 && $past(rst_type_o) != 2'b10 &&
     !$past(reg_we_i && reg_addr_i == 2'd2)) |-> $past(chip_rst_i && core_rst_i));

  // R12
  type_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(rst_type_o) && !$past(reg_we_i && reg_addr_i == 2'd2)) |-> core_rst_o);

  // R8
  req_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |->
      $past(wdog_timeout_i || (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i == 2'b11)));

  // R8
  req_dbg_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_req_o) && $past(dbg_rst_o)) |-> $past(wdog_timeout_i));
endmodule

bind rst_type_ctrl rst_type_ctrl_chk #(.QUAL_CYC(QUAL_CYC)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .core_rst_i     (core_rst_i),
  .chip_rst_i     (chip_rst_i),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_wdata_i    (reg_wdata_i),
  .wdog_timeout_i (wdog_timeout_i),
  .core_rst_o     (core_rst_o),
  .dbg_rst_o      (dbg_rst_o),
  .rst_type_o     (rst_type_o),
  .sys_rst_req_o  (sys_rst_req_o)
);

// File: tb/tb_rst_type_ctrl.sv
module tb_rst_type_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic core_rst_i = 1'b0, chip_rst_i = 1'b0, sys_rst_i = 1'b0;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0, reg_wdata_i = 2'd0;
  logic wdog_timeout_i = 1'b0;
  logic core_rst_o, dbg_rst_o, sys_rst_req_o;
  logic [1:0] rst_type_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rst_type_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .core_rst_i(core_rst_i), .chip_rst_i(chip_rst_i),
    .sys_rst_i(sys_rst_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .wdog_timeout_i(wdog_timeout_i),
    .core_rst_o(core_rst_o), .dbg_rst_o(dbg_rst_o), .rst_type_o(rst_type_o),
    .sys_rst_req_o(sys_rst_req_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc(1);
    reg_we_i = 1'b0;
  endtask

  task automatic tmo();
    wdog_timeout_i = 1'b1;
    cyc(1);
    wdog_timeout_i = 1'b0;
  endtask

  task automatic t_reset();
    sys_rst_i = 1'b1;
    cyc(3);
    chk("R1 core", core_rst_o, 1); chk("R1 dbg", dbg_rst_o, 1);
    chk("R1 type", rst_type_o, 0); chk("R1 req", sys_rst_req_o, 0);
    rst_ni = 1'b1;
    cyc(2);
    chk("R7 dbg held", dbg_rst_o, 1);
    sys_rst_i = 1'b0;
    cyc(1);
    chk("R7 dbg follows", dbg_rst_o, 0);
    cyc(12);
    chk("R1 tail", core_rst_o, 1);
    cyc(1);
    chk("R1 release", core_rst_o, 0);
  endtask

  task automatic t_core();
    core_rst_i = 1'b1;
    cyc(7);
    chk("R2 early", core_rst_o, 0); chk("R2 type early", rst_type_o, 0);
    cyc(1);
    chk("R2 core", core_rst_o, 1); chk("R2 type", rst_type_o, 1);
    cyc(5);
    chk("R4 held", core_rst_o, 1);
    core_rst_i = 1'b0;
    cyc(16);
    chk("R4 tail", core_rst_o, 1);
    cyc(1);
    chk("R4 release", core_rst_o, 0);
  endtask

  task automatic t_short();
    wr(2'd2, 2'b11);
    chk("R11 clear all", rst_type_o, 0);
    core_rst_i = 1'b1; cyc(7); core_rst_i = 1'b0; cyc(1);
    chk("R3 core", core_rst_o, 0); chk("R3 type", rst_type_o, 0);
    core_rst_i = 1'b1; cyc(4); core_rst_i = 1'b0; cyc(1);
    core_rst_i = 1'b1; cyc(4); core_rst_i = 1'b0; cyc(1);
    chk("R3 broken core", core_rst_o, 0); chk("R3 broken type", rst_type_o, 0);
  endtask

  task automatic t_chip();
    chip_rst_i = 1'b1; cyc(10);
    chk("R5 chip alone core", core_rst_o, 0); chk("R5 chip alone type", rst_type_o, 0);
    chip_rst_i = 1'b0; cyc(1);
    core_rst_i = 1'b1; chip_rst_i = 1'b1; cyc(8);
    chk("R5 chip core", core_rst_o, 1); chk("R5 chip type", rst_type_o, 2);
    core_rst_i = 1'b0; chip_rst_i = 1'b0; cyc(17);
    chk("R5 release", core_rst_o, 0);
  endtask

  task automatic t_prio();
    core_rst_i = 1'b1; chip_rst_i = 1'b1; sys_rst_i = 1'b1; cyc(8);
    chk("R6 prio", rst_type_o, 3);
    core_rst_i = 1'b0; chip_rst_i = 1'b0; sys_rst_i = 1'b0; cyc(17);
    chk("R12 held", rst_type_o, 3);
    wr(2'd2, 2'b01);
    chk("R11 clear bit0", rst_type_o, 2);
    wr(2'd3, 2'b11);
    chk("R11 addr3 no effect", rst_type_o, 2);
    wr(2'd2, 2'b10);
    chk("R11 clear bit1", rst_type_o, 0);
    sys_rst_i = 1'b1; cyc(1);
    chk("R7 dbg rise", dbg_rst_o, 1);
    cyc(10);
    chk("R7 sys alone core", core_rst_o, 0); chk("R7 sys alone type", rst_type_o, 0);
    sys_rst_i = 1'b0; cyc(1);
  endtask

  task automatic t_upgrade();
    core_rst_i = 1'b1; cyc(8);
    chk("R6 core first", rst_type_o, 1);
    chip_rst_i = 1'b1; cyc(7);
    chk("R6 chip pending", rst_type_o, 1);
    cyc(1);
    chk("R6 chip upgrade", rst_type_o, 2);
    sys_rst_i = 1'b1; cyc(8);
    chk("R6 sys upgrade", rst_type_o, 3);
    core_rst_i = 1'b0; chip_rst_i = 1'b0; sys_rst_i = 1'b0; cyc(17);
    chk("R12 type kept", rst_type_o, 3);
  endtask

  task automatic t_requal();
    core_rst_i = 1'b1; cyc(8);
    core_rst_i = 1'b0; cyc(5);
    core_rst_i = 1'b1; cyc(8);
    chk("R12 requal core", core_rst_o, 1); chk("R12 requal type", rst_type_o, 1);
    core_rst_i = 1'b0; cyc(16);
    chk("R12 tail", core_rst_o, 1);
    cyc(1);
    chk("R12 release", core_rst_o, 0);
  endtask

  task automatic t_w1c_race();
    wr(2'd2, 2'b11);
    core_rst_i = 1'b1; cyc(7);
    wr(2'd2, 2'b11);
    chk("R11 event wins", rst_type_o, 1);
    core_rst_i = 1'b0; cyc(17);
  endtask

  task automatic sys_clear(input string tag);
    sys_rst_i = 1'b1; cyc(7);
    chk({tag, " req kept"}, sys_rst_req_o, 1);
    cyc(1);
    chk({tag, " req cleared"}, sys_rst_req_o, 0);
  endtask

  task automatic t_dbg();
    wr(2'd0, 2'b01);
    chk("R8 other value", sys_rst_req_o, 0);
    wr(2'd0, 2'b11);
    chk("R8 request", sys_rst_req_o, 1);
    chk("R10 no core", core_rst_o, 0); chk("R10 no type", rst_type_o, 1);
    cyc(5);
    chk("R10 sticky", sys_rst_req_o, 1);
    sys_clear("R10");
    wr(2'd0, 2'b11);
    chk("R8 gated", sys_rst_req_o, 0);
    sys_rst_i = 1'b0; cyc(1);
  endtask

  task automatic t_wdog();
    wr(2'd1, 2'b01); tmo();
    chk("R9 field 01", sys_rst_req_o, 0);
    wr(2'd1, 2'b11); tmo();
    chk("R9 fire", sys_rst_req_o, 1);
    sys_clear("R9");
    sys_rst_i = 1'b0; cyc(1);
    tmo();
    chk("R9 fired no repeat", sys_rst_req_o, 0);
    core_rst_i = 1'b1; cyc(8); core_rst_i = 1'b0; cyc(17);
    tmo();
    chk("R9 field cleared", sys_rst_req_o, 0);
    wr(2'd1, 2'b11); tmo();
    chk("R9 rearmed", sys_rst_req_o, 1);
    sys_clear("R9 end");
    sys_rst_i = 1'b0; cyc(1);
  endtask

  initial begin
    fork
      begin
        cyc(1);
        t_reset(); t_core(); t_short(); t_chip(); t_prio();
        t_upgrade(); t_requal(); t_w1c_race(); t_dbg(); t_wdog();
      end
      begin
        cyc(200000);
        chk("watchdog expired", 1, 0);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule